// File: doc/BRIEF.md
# Bus Cycle Capture Latch

This block watches a parallel backplane bus and takes a snapshot of each completed transfer: the address lines A31..A01, the 32 data lines, the six address-modifier lines and the transfer control lines. The snapshot feeds two destinations. The first is a set of display vectors for a front-panel indicator row. The second is a set of readback registers that always hold the raw, unmasked values of the last captured transfer. All bus inputs arrive as active-high logic levels that have already been sensed. The block runs on one system clock, and the handshake lines are resynchronized inside it.

The capture instant follows the termination handshake. A snapshot is taken when the acknowledge or bus-error line is released. If a transfer ends its data strobes without ever seeing a termination, the snapshot is taken when the strobes end instead. Bus lines pass through a delay line as long as the synchronizer, so the captured values are those present on the last sample at which the handshake was still asserted.

Display-all mode controls how the display is updated. With it off, the display update is interpretive: narrow transfers refresh only the lanes they actually drive. With it on, every line is refreshed. Either halt input freezes all captured state. The bus system-reset line clears all of it. Bus-grant daisy-chain lines are captured separately, when bus-busy is asserted.

Top module: `busCycleLatch`

## Requirements
- R1: The snapshot is taken on the release of the termination (acknowledge or bus error). Captured values are those present while the termination was still asserted. Outputs change three clock edges after the release is first sampled, and not at any other time.
- R2: If a transfer's data strobes end and no termination was seen since the strobes began, the snapshot is taken at the strobe end, from the last sample with a strobe asserted.
- R3: regCtrl holds flag bits that record activity on the handshake lines. Bit 9 is set once the acknowledge line is seen asserted, and bit 8 is set once the bus-error line is seen asserted. A flag sets while its line is still asserted, before any capture happens. Both flags clear when the next transfer's data strobes begin. The remaining bits of regCtrl are bit 7 iack, bit 6 iackin, bit 5 iackout, bit 4 address strobe, bit 3 ds0, bit 2 ds1, bit 1 write and bit 0 lword. The strobe bits take the values seen while the data strobes were active.
- R4: With display-all off, a byte transfer (lword low and exactly one data strobe) updates only dispData[7:0]. All other data display bits keep their values.
- R5: With display-all off, a short-address transfer (modifier 0x29 or 0x2D) updates only dispAddr[14:0] (A15..A01) and dispData[15:0]. If the transfer is also a byte transfer, the R4 data mask applies as well.
- R6: With display-all on, every address, data and modifier display bit is updated. The readback registers regAddr, regData and regAm are always written unmasked. dispAm is always written in full.
- R7: While hwHalt or swHalt is high, no display vector, readback register, activity flag or grant capture changes.
- R8: sysReset high clears every display vector, readback register and flag on the next clock edge. It takes priority over halt.
- R9: dispGrant is loaded on the assertion of bus-busy, with bits 3:0 from busGrantIn and bits 7:4 from busGrantOut. At any other time it ignores changes on the grant lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of the block logic |
| sysReset | input | 1 | Bus system reset, clears captured state |
| displayAll | input | 1 | 1 = show every line, 0 = interpretive masking |
| hwHalt | input | 1 | Hardware hold-on-error state |
| swHalt | input | 1 | Software hold request |
| addrIn | input | 31 | Bus address lines A31..A01 |
| dataIn | input | 32 | Bus data lines D31..D00 |
| amIn | input | 6 | Address modifier |
| asIn | input | 1 | Address strobe |
| ds0In | input | 1 | Data strobe 0 |
| ds1In | input | 1 | Data strobe 1 |
| writeIn | input | 1 | Write line |
| lwordIn | input | 1 | Long-word line |
| iackIn | input | 1 | Interrupt acknowledge |
| iackinIn | input | 1 | Interrupt acknowledge daisy-chain in |
| iackoutIn | input | 1 | Interrupt acknowledge daisy-chain out |
| dtackIn | input | 1 | Transfer acknowledge |
| berrIn | input | 1 | Bus error |
| bbsyIn | input | 1 | Bus busy |
| busGrantIn | input | 4 | Bus grant daisy-chain inputs |
| busGrantOut | input | 4 | Bus grant daisy-chain outputs |
| dispAddr | output | 31 | Address display vector |
| dispData | output | 32 | Data display vector |
| dispAm | output | 6 | Modifier display vector |
| dispGrant | output | 8 | Captured grant lines |
| regAddr | output | 31 | Readback address |
| regData | output | 32 | Readback data |
| regAm | output | 6 | Readback modifier |
| regCtrl | output | 10 | Readback control lines and activity flags |

## Verification
The hardest situation to reach is a capture whose sampled values differ from what the bus shows at the moment the capture is decided. The stimulus creates this on purpose. It keeps address and data valid only while the termination or strobe is still asserted, and it replaces every line with its complement in the same step as the release. A capture taken from the wrong stage of the delay line therefore shows up as inverted bits. A second hard case is the masked display. To make a dropped lane update visible, a fully populated transfer is first laid down, and narrow or short transfers with contrasting patterns follow on top of it. The acknowledge flag is also read while the acknowledge line is held. This shows that the flag moves before the data registers do.

// File: rtl/busCapPkg.sv
package busCapPkg;
  localparam int ADDR_W      = 31;
  localparam int DATA_W      = 32;
  localparam int AM_W        = 6;
  localparam int GRANT_N     = 4;
  localparam int SHORT_AW    = 15;
  localparam int SHORT_DW    = 16;
  localparam int BYTE_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int CTRL_W      = 10;
  localparam int GRANT_W     = 2 * GRANT_N;

  localparam logic [AM_W-1:0] AM_SHORT_SUP = 6'h2D;
  localparam logic [AM_W-1:0] AM_SHORT_USR = 6'h29;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
    logic [AM_W-1:0]    am;
    logic               as;
    logic               ds0;
    logic               ds1;
    logic               write;
    logic               lword;
    logic               iack;
    logic               iackin;
    logic               iackout;
    logic [GRANT_W-1:0] grant;
  } busSnapT;

  typedef struct packed {
    logic capture;
    logic cycleStart;
    logic dtackSet;
    logic berrSet;
    logic grantCap;
    logic strobeLive;
  } capStrobeT;
endpackage

// File: rtl/busCapCtrl.sv
module busCapCtrl
  import busCapPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dtackIn,
  input  logic      berrIn,
  input  logic      ds0In,
  input  logic      ds1In,
  input  logic      bbsyIn,
  output capStrobeT strobes
);
  localparam int CUR  = SYNC_STAGES - 1;
  localparam int LAST = SYNC_STAGES;

  logic [SYNC_STAGES:0]   dsPipe, termPipe, bbPipe;
  logic [SYNC_STAGES-1:0] dtPipe, brPipe;
  logic termSeen;
  logic termFall, strobeEnd, cycleStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dsPipe   <= '0;
      termPipe <= '0;
      bbPipe   <= '0;
      dtPipe   <= '0;
      brPipe   <= '0;
    end else begin
      dsPipe   <= {dsPipe[SYNC_STAGES-1:0], ds0In | ds1In};
      termPipe <= {termPipe[SYNC_STAGES-1:0], dtackIn | berrIn};
      bbPipe   <= {bbPipe[SYNC_STAGES-1:0], bbsyIn};
      dtPipe   <= {dtPipe[SYNC_STAGES-2:0], dtackIn};
      brPipe   <= {brPipe[SYNC_STAGES-2:0], berrIn};
    end
  end

  assign termFall   = termPipe[LAST] & ~termPipe[CUR];
  assign strobeEnd  = dsPipe[LAST] & ~dsPipe[CUR];
  assign cycleStart = dsPipe[CUR] & ~dsPipe[LAST];

  // remembers whether the current transfer has been terminated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              termSeen <= 1'b0;
    else if (termPipe[CUR]) termSeen <= 1'b1;
    else if (cycleStart)    termSeen <= 1'b0;
  end

  always_comb begin
    strobes.capture    = termFall | (strobeEnd & ~termSeen & ~termPipe[CUR]);
    strobes.cycleStart = cycleStart;
    strobes.dtackSet   = dtPipe[CUR];
    strobes.berrSet    = brPipe[CUR];
    strobes.grantCap   = bbPipe[CUR] & ~bbPipe[LAST];
    strobes.strobeLive = dsPipe[LAST];
  end

  // R1/R2: one transfer yields one capture, never two on adjacent edges
  p_single_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
endmodule

// File: rtl/busCapData.sv
module busCapData
  import busCapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sysReset,
  input  logic               displayAll,
  input  logic               hwHalt,
  input  logic               swHalt,
  input  busSnapT            busIn,
  input  capStrobeT          strobes,
  output logic [ADDR_W-1:0]  dispAddr,
  output logic [DATA_W-1:0]  dispData,
  output logic [AM_W-1:0]    dispAm,
  output logic [GRANT_W-1:0] dispGrant,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regData,
  output logic [AM_W-1:0]    regAm,
  output logic [CTRL_W-1:0]  regCtrl
);
  localparam logic [ADDR_W-1:0] SHORT_ADDR_MASK = {{(ADDR_W-SHORT_AW){1'b0}}, {SHORT_AW{1'b1}}};
  localparam logic [DATA_W-1:0] SHORT_DATA_MASK = {{(DATA_W-SHORT_DW){1'b0}}, {SHORT_DW{1'b1}}};
  localparam logic [DATA_W-1:0] BYTE_DATA_MASK  = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  busSnapT dly [SYNC_STAGES+1];
  busSnapT aligned;
  logic [2:0] strobeSnap, curStrobe;
  logic [7:0] ctrlLatch;
  logic dtackFlag, berrFlag;
  logic hold, byteXfer, shortXfer;
  logic [ADDR_W-1:0] addrMask;
  logic [DATA_W-1:0] dataMask;

  // delay line matches synchronizer depth plus the edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC_STAGES; i++) dly[i] <= '0;
    end else begin
      dly[0] <= busIn;
      for (int i = 1; i <= SYNC_STAGES; i++) dly[i] <= dly[i-1];
    end
  end
  assign aligned = dly[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   strobeSnap <= '0;
    else if (strobes.strobeLive) strobeSnap <= {aligned.as, aligned.ds0, aligned.ds1};
  end
  assign curStrobe = strobes.strobeLive ? {aligned.as, aligned.ds0, aligned.ds1} : strobeSnap;

  assign hold      = hwHalt | swHalt;
  assign byteXfer  = ~aligned.lword & (curStrobe[1] ^ curStrobe[0]);
  assign shortXfer = (aligned.am == AM_SHORT_SUP) || (aligned.am == AM_SHORT_USR);

  always_comb begin
    addrMask = '1;
    dataMask = '1;
    if (!displayAll) begin
      if (shortXfer) begin
        addrMask = SHORT_ADDR_MASK;
        dataMask = SHORT_DATA_MASK;
      end
      if (byteXfer) dataMask = dataMask & BYTE_DATA_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispAddr <= '0; dispData <= '0; dispAm <= '0; dispGrant <= '0;
      regAddr <= '0; regData <= '0; regAm <= '0; ctrlLatch <= '0;
      dtackFlag <= 1'b0; berrFlag <= 1'b0;
    end else if (sysReset) begin
      dispAddr <= '0; dispData <= '0; dispAm <= '0; dispGrant <= '0;
      regAddr <= '0; regData <= '0; regAm <= '0; ctrlLatch <= '0;
      dtackFlag <= 1'b0; berrFlag <= 1'b0;
    end else if (!hold) begin
      if (strobes.capture) begin
        regAddr   <= aligned.addr;
        regData   <= aligned.data;
        regAm     <= aligned.am;
        ctrlLatch <= {aligned.iack, aligned.iackin, aligned.iackout, curStrobe,
                      aligned.write, aligned.lword};
        dispAddr  <= (dispAddr & ~addrMask) | (aligned.addr & addrMask);
        dispData  <= (dispData & ~dataMask) | (aligned.data & dataMask);
        dispAm    <= aligned.am;
      end
      if (strobes.grantCap) dispGrant <= aligned.grant;
      if (strobes.dtackSet)        dtackFlag <= 1'b1;
      else if (strobes.cycleStart) dtackFlag <= 1'b0;
      if (strobes.berrSet)         berrFlag <= 1'b1;
      else if (strobes.cycleStart) berrFlag <= 1'b0;
    end
  end

  assign regCtrl = {dtackFlag, berrFlag, ctrlLatch};

  p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture && !sysReset |=> $stable(regAddr) && $stable(regData));
  p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && byteXfer && !displayAll && !hold && !sysReset
      |=> $stable(dispData[DATA_W-1:BYTE_W]));
  p_short_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && shortXfer && !displayAll && !hold && !sysReset
      |=> $stable(dispAddr[ADDR_W-1:SHORT_AW]));
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    hold && !sysReset |=> $stable(regData) && $stable(dispData) && $stable(regCtrl)
                          && $stable(dispGrant));
  p_sysreset_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> regData == '0 && dispAddr == '0 && regCtrl == '0 && dispGrant == '0);
  p_grant_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.grantCap && !sysReset |=> $stable(dispGrant));
endmodule

// File: rtl/busCycleLatch.sv
module busCycleLatch
  import busCapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sysReset,
  input  logic               displayAll,
  input  logic               hwHalt,
  input  logic               swHalt,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [AM_W-1:0]    amIn,
  input  logic               asIn,
  input  logic               ds0In,
  input  logic               ds1In,
  input  logic               writeIn,
  input  logic               lwordIn,
  input  logic               iackIn,
  input  logic               iackinIn,
  input  logic               iackoutIn,
  input  logic               dtackIn,
  input  logic               berrIn,
  input  logic               bbsyIn,
  input  logic [GRANT_N-1:0] busGrantIn,
  input  logic [GRANT_N-1:0] busGrantOut,
  output logic [ADDR_W-1:0]  dispAddr,
  output logic [DATA_W-1:0]  dispData,
  output logic [AM_W-1:0]    dispAm,
  output logic [GRANT_W-1:0] dispGrant,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regData,
  output logic [AM_W-1:0]    regAm,
  output logic [CTRL_W-1:0]  regCtrl
);
  busSnapT   busNow;
  capStrobeT strobes;

  always_comb begin
    busNow.addr    = addrIn;
    busNow.data    = dataIn;
    busNow.am      = amIn;
    busNow.as      = asIn;
    busNow.ds0     = ds0In;
    busNow.ds1     = ds1In;
    busNow.write   = writeIn;
    busNow.lword   = lwordIn;
    busNow.iack    = iackIn;
    busNow.iackin  = iackinIn;
    busNow.iackout = iackoutIn;
    busNow.grant   = {busGrantOut, busGrantIn};
  end

  busCapCtrl uCtrl (
    .clk(clk), .rstN(rstN), .dtackIn(dtackIn), .berrIn(berrIn),
    .ds0In(ds0In), .ds1In(ds1In), .bbsyIn(bbsyIn), .strobes(strobes)
  );

  busCapData uData (
    .clk(clk), .rstN(rstN), .sysReset(sysReset), .displayAll(displayAll),
    .hwHalt(hwHalt), .swHalt(swHalt), .busIn(busNow), .strobes(strobes),
    .dispAddr(dispAddr), .dispData(dispData), .dispAm(dispAm), .dispGrant(dispGrant),
    .regAddr(regAddr), .regData(regData), .regAm(regAm), .regCtrl(regCtrl)
  );
endmodule

// File: tb/tb_busCycleLatch.sv
`timescale 1ns/1ps
module tb_busCycleLatch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysReset = 0, displayAll = 0, hwHalt = 0, swHalt = 0;
  logic [30:0] addrIn = '0;
  logic [31:0] dataIn = '0;
  logic [5:0]  amIn = '0;
  logic asIn = 0, ds0In = 0, ds1In = 0, writeIn = 0, lwordIn = 0;
  logic iackIn = 0, iackinIn = 0, iackoutIn = 0, dtackIn = 0, berrIn = 0, bbsyIn = 0;
  logic [3:0] busGrantIn = '0, busGrantOut = '0;
  logic [30:0] dispAddr, regAddr;
  logic [31:0] dispData, regData;
  logic [5:0]  dispAm, regAm;
  logic [7:0]  dispGrant;
  logic [9:0]  regCtrl;

  int checks = 0;
  int errors = 0;
  logic [30:0] expDA = '0, expRA = '0;
  logic [31:0] expDD = '0, expRD = '0;
  logic [5:0]  expDAm = '0, expRAm = '0;
  logic [9:0]  expRC = '0;
  logic [7:0]  expGrant = '0;

  always #2.5 clk = ~clk;

  busCycleLatch dut (.*);

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    checkVal({tag, " dispAddr"}, 64'(dispAddr), 64'(expDA));
    checkVal({tag, " dispData"}, 64'(dispData), 64'(expDD));
    checkVal({tag, " dispAm"}, 64'(dispAm), 64'(expDAm));
    checkVal({tag, " regAddr"}, 64'(regAddr), 64'(expRA));
    checkVal({tag, " regData"}, 64'(regData), 64'(expRD));
    checkVal({tag, " regAm"}, 64'(regAm), 64'(expRAm));
    checkVal({tag, " regCtrl"}, 64'(regCtrl), 64'(expRC));
    checkVal({tag, " dispGrant"}, 64'(dispGrant), 64'(expGrant));
  endtask

  // term: 0 none (strobe-end fallback), 1 acknowledge, 2 bus error
  task automatic runCycle(input string tag, input logic [30:0] a, input logic [31:0] d,
                          input logic [5:0] am, input logic lw, input logic d0,
                          input logic d1, input logic wr, input int term);
    logic hold, isShort, isByte;
    logic [30:0] aMask;
    logic [31:0] dMask;
    hold = hwHalt | swHalt;
    @(negedge clk);
    addrIn = a; dataIn = d; amIn = am; lwordIn = lw; writeIn = wr; asIn = 1;
    repeat (2) @(negedge clk);
    ds0In = d0; ds1In = d1;
    repeat (4) @(negedge clk);
    if (term != 0) begin
      if (term == 1) dtackIn = 1; else berrIn = 1;
      repeat (4) @(negedge clk);
      if (term == 1) begin
        // R3: flag already set while acknowledge held, data not yet captured
        checkVal({tag, " R3 flag before capture"}, 64'(regCtrl[9]), hold ? 64'(expRC[9]) : 64'd1);
        checkVal({tag, " R1 no early capture"}, 64'(regData), 64'(expRD));
      end
      ds0In = 0; ds1In = 0; asIn = 0;
      repeat (4) @(negedge clk);
      dtackIn = 0; berrIn = 0;
    end else begin
      ds0In = 0; ds1In = 0; asIn = 0;
    end
    addrIn = ~a; dataIn = ~d; amIn = ~am;
    repeat (8) @(negedge clk);
    if (!hold) begin
      isShort = (am == 6'h29) || (am == 6'h2D);
      isByte  = !lw && (d0 ^ d1);
      aMask = '1; dMask = '1;
      if (!displayAll) begin
        if (isShort) begin aMask = 31'h0000_7FFF; dMask = 32'h0000_FFFF; end
        if (isByte) dMask = dMask & 32'h0000_00FF;
      end
      expRA = a; expRD = d; expRAm = am;
      expRC = {term == 1, term == 2, 3'b000, 1'b1, d0, d1, wr, lw};
      expDA = (expDA & ~aMask) | (a & aMask);
      expDD = (expDD & ~dMask) | (d & dMask);
      expDAm = am;
    end
    checkAll(tag);
  endtask

  task automatic grantTest();
    @(negedge clk);
    busGrantIn = 4'hA; busGrantOut = 4'h5;
    repeat (2) @(negedge clk);
    bbsyIn = 1;
    repeat (6) @(negedge clk);
    expGrant = 8'h5A;
    checkVal("R9 grant on bbsy", 64'(dispGrant), 64'(expGrant));
    busGrantIn = 4'h3; busGrantOut = 4'hC;
    repeat (6) @(negedge clk);
    checkVal("R9 grant change ignored", 64'(dispGrant), 64'(expGrant));
    bbsyIn = 0;
    repeat (6) @(negedge clk);
    checkVal("R9 bbsy release ignored", 64'(dispGrant), 64'(expGrant));
  endtask

  task automatic resetTest();
    @(negedge clk);
    sysReset = 1;
    @(negedge clk);
    sysReset = 0;
    expDA = '0; expDD = '0; expDAm = '0; expRA = '0; expRD = '0; expRAm = '0;
    expRC = '0; expGrant = '0;
    repeat (2) @(negedge clk);
    checkAll("R8 sysReset clear");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    checkAll("reset state R8");
    runCycle("R1 full ack cycle R6", 31'h5A5A_1234, 32'hDEAD_BEEF, 6'h39, 1, 1, 1, 1, 1);
    runCycle("R2 strobe-end fallback", 31'h1357_9BDF, 32'h0F1E_2D3C, 6'h09, 1, 1, 1, 0, 0);
    runCycle("R4 byte cycle", 31'h2222_3333, 32'hA1B2_C3D4, 6'h39, 0, 1, 0, 1, 1);
    runCycle("R5 short cycle berr R3", 31'h7FFF_0ACE, 32'h5555_6789, 6'h29, 0, 1, 1, 0, 2);
    runCycle("R5 short byte cycle", 31'h0000_4321, 32'hFFFF_FF99, 6'h2D, 0, 0, 1, 1, 1);
    displayAll = 1;
    runCycle("R6 display-all short", 31'h6666_1111, 32'h1234_5678, 6'h2D, 0, 1, 0, 1, 1);
    displayAll = 0;
    hwHalt = 1;
    runCycle("R7 hw halt", 31'h0BAD_0BAD, 32'hCAFE_F00D, 6'h39, 1, 1, 1, 1, 1);
    hwHalt = 0; swHalt = 1;
    runCycle("R7 sw halt", 31'h0DEF_0ABC, 32'h8765_4321, 6'h09, 1, 1, 1, 0, 2);
    swHalt = 0;
    runCycle("R1 after halt release", 31'h1111_2222, 32'h3333_4444, 6'h0D, 1, 1, 1, 1, 1);
    grantTest();
    resetTest();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule